// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter

This block is a bus-attached parallel I/O peripheral with two ports, A and B. Each port has an output latch, a per-bit direction register and a control register. It also has two handshake lines. Line 1 is always an input and its chosen edge raises an interrupt flag. Line 2 is software-selectable. As an input it is a second edge-triggered interrupt source. As an output it is either a level under direct software control or an automatic strobe.

A processor reaches the block through a 2-bit register select, chip select, single-cycle read and write strobes and a data bus. Read data is combinational from the current state and the pins. Register updates and side effects, such as flag clearing and strobe launch, take effect at the clock edge that ends the access. Each port has its own interrupt request output, which is a combination of its flags and their enables.

On port A the line 2 strobe is launched by a read of the data register. On port B it is launched by a write of the data register. This suits a receive handshake on A and a transmit handshake on B.

Top module: `par_io_adapter`

## Requirements
- R1: The register select decodes 0 as port A data/direction, 1 as control A, 2 as port B data/direction and 3 as control B. At a data/direction address, control bit 2 set selects the output latch and bit 2 clear selects the direction register, for both reads and writes.
- R2: A read of a port's output latch returns (latch AND direction) OR (pin input AND NOT direction).
- R3: The port output pins always equal latch AND direction. A write to either register is visible on the pins in the cycle after the write.
- R4: A control read returns flag 1 in bit 7, flag 2 in bit 6 and the stored bits 5..0. A control write changes only bits 5..0.
- R5: Control bit 1 selects the active line 1 edge: 1 means rising and 0 means falling. An active edge sets flag 1 at the clock edge that samples the new pin level.
- R6: With bit 5 clear, control bit 4 selects the active line 2 edge (1 rising) and an active edge sets flag 2.
- R7: A port's interrupt output is high when (flag 1 AND bit 0) OR (flag 2 AND bit 3 AND NOT bit 5).
- R8: A read of a port's output latch clears both flags of that port. An active edge in the same cycle still sets its flag.
- R9: Control bit 5 makes line 2 an output and drives its output enable high. With bits 5 and 4 both set, a control write drives line 2 to the written bit 3.
- R10: With bit 5 set and bit 4 clear (strobe mode), a read of the port A latch drives line A2 low. If bit 3 is set, the line goes high again one cycle later, so it is low for exactly one clock.
- R11: In strobe mode, a write of the port B latch drives line B2 low, with the same release rules as port A.
- R12: In strobe mode with bit 3 clear, line 2 returns high on an active line 1 edge only if flag 1 was clear before that edge.
- R13: While line 2 is an output, control bit 6 reads 0 and line 2 pin activity sets no flag and raises no interrupt.
- R14: Reset clears all registers and flags, leaves port pins and interrupts low, drives both line 2 outputs high and their enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| rsel | input | 2 | Register select |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| irq_a | output | 1 | Port A interrupt request |
| irq_b | output | 1 | Port B interrupt request |
| pa_in | input | DW | Port A pin inputs |
| pa_out | output | DW | Port A driven value (latch AND direction) |
| pb_in | input | DW | Port B pin inputs |
| pb_out | output | DW | Port B driven value |
| a1_in | input | 1 | Port A line 1 input |
| a2_in | input | 1 | Port A line 2 input |
| a2_out | output | 1 | Port A line 2 output value |
| a2_oe | output | 1 | Port A line 2 output enable |
| b1_in | input | 1 | Port B line 1 input |
| b2_in | input | 1 | Port B line 2 input |
| b2_out | output | 1 | Port B line 2 output value |
| b2_oe | output | 1 | Port B line 2 output enable |

## Verification
A corrupted latch or direction bit appears on the port pins one cycle after the write that should have set it. A wrong mask appears in the very next latch read. A flag that is set or cleared wrongly is visible at once on the interrupt output when enabled, and on any control read. A strobe that sticks low or releases early shows on the line 2 output in the cycle after the launching access, or at the next line 1 edge. Every cycle of the random phase compares pins, interrupts and line 2 outputs against a bench model, so most faults surface within one or two cycles of the access that exposes them.

// File: rtl/par_io_pkg.sv
package par_io_pkg;
  localparam int CW         = 8;
  localparam int C_L1_IE    = 0;
  localparam int C_L1_RISE  = 1;
  localparam int C_SEL_DATA = 2;
  localparam int C_L2_B3    = 3;
  localparam int C_L2_B4    = 4;
  localparam int C_L2_OUT   = 5;
  localparam int C_FLAG2    = 6;
  localparam int C_FLAG1    = 7;
  localparam int C_WR_BITS  = 6;

  typedef enum logic [1:0] {
    RS_DAT_A = 2'd0,
    RS_CTL_A = 2'd1,
    RS_DAT_B = 2'd2,
    RS_CTL_B = 2'd3
  } rsel_e;
endpackage

// File: rtl/par_io_edge.sv
module par_io_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic rise_sel,
  output logic active
);
  logic prev_q;

  always_comb begin
    active = rise_sel ? (sig & ~prev_q) : (~sig & prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end
endmodule

// File: rtl/par_io_dir_regs.sv
module par_io_dir_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          sel_data,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] rd_view,
  output logic [DW-1:0] pins_out
);
  logic [DW-1:0] out_q, out_d;
  logic [DW-1:0] ddr_q, ddr_d;
  logic          out_en, ddr_en;

  always_comb begin
    out_en = wr_en & sel_data;
    ddr_en = wr_en & ~sel_data;
    out_d  = out_en ? wdata : out_q;
    ddr_d  = ddr_en ? wdata : ddr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      ddr_q <= '0;
    end else begin
      out_q <= out_d;
      ddr_q <= ddr_d;
    end
  end

  always_comb begin
    pins_out = out_q & ddr_q;
    rd_view  = sel_data ? ((out_q & ddr_q) | (pin_in & ~ddr_q)) : ddr_q;
  end

  // R3
  pins_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_data) |=> (pins_out == ($past(wdata) & ddr_q)));
endmodule

// File: rtl/par_io_handshake.sv
module par_io_handshake
  import par_io_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr,
  input  logic [C_WR_BITS-1:0] ctl_wdata,
  input  logic                 data_rd,
  input  logic                 strobe_trig,
  input  logic                 l1_in,
  input  logic                 l2_in,
  output logic [CW-1:0]        ctl_view,
  output logic                 sel_data,
  output logic                 irq,
  output logic                 l2_out,
  output logic                 l2_oe
);
  logic [C_WR_BITS-1:0] ctl_q, ctl_d;
  logic f1_q, f1_d, f2_q, f2_d, l2_q, l2_d;
  logic l1_act, l2_act, l2_in_act, strobe_mode;

  par_io_edge u_l1_edge (
    .clk(clk), .rst_n(rst_n), .sig(l1_in),
    .rise_sel(ctl_q[C_L1_RISE]), .active(l1_act)
  );

  par_io_edge u_l2_edge (
    .clk(clk), .rst_n(rst_n), .sig(l2_in),
    .rise_sel(ctl_q[C_L2_B4]), .active(l2_act)
  );

  always_comb begin
    strobe_mode = ctl_q[C_L2_OUT] & ~ctl_q[C_L2_B4];
    l2_in_act   = l2_act & ~ctl_q[C_L2_OUT];
    ctl_d       = ctl_wr ? ctl_wdata : ctl_q;
    f1_d        = l1_act | (f1_q & ~data_rd);
    f2_d        = l2_in_act | (f2_q & ~data_rd);
    l2_d        = l2_q;
    if (strobe_mode && ctl_q[C_L2_B3] && !l2_q)
      l2_d = 1'b1;
    if (strobe_mode && !ctl_q[C_L2_B3] && l1_act && !f1_q && !l2_q)
      l2_d = 1'b1;
    if (strobe_mode && strobe_trig)
      l2_d = 1'b0;
    if (ctl_wr && ctl_wdata[C_L2_OUT] && ctl_wdata[C_L2_B4])
      l2_d = ctl_wdata[C_L2_B3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
      l2_q  <= 1'b1;
    end else begin
      ctl_q <= ctl_d;
      f1_q  <= f1_d;
      f2_q  <= f2_d;
      l2_q  <= l2_d;
    end
  end

  always_comb begin
    ctl_view = {f1_q, f2_q & ~ctl_q[C_L2_OUT], ctl_q};
    sel_data = ctl_q[C_SEL_DATA];
    irq      = (f1_q & ctl_q[C_L1_IE]) |
               (f2_q & ctl_q[C_L2_B3] & ~ctl_q[C_L2_OUT]);
    l2_out   = l2_q;
    l2_oe    = ctl_q[C_L2_OUT];
  end

  // R5
  l1_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_act |=> f1_q);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !l1_act) |=> !f1_q);

  // R9
  set_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[C_L2_OUT] && ctl_wdata[C_L2_B4]) |=> (l2_out == $past(ctl_wdata[C_L2_B3])));

  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_mode && ctl_q[C_L2_B3] && !l2_q && !strobe_trig && !ctl_wr) |=> l2_out);

  // R13
  no_flag2_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[C_L2_OUT] && !ctl_wr && !f2_q) |=> !f2_q);
endmodule

// File: rtl/par_io_adapter.sv
module par_io_adapter
  import par_io_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    rsel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_a,
  output logic          irq_b,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  input  logic          a1_in,
  input  logic          a2_in,
  output logic          a2_out,
  output logic          a2_oe,
  input  logic          b1_in,
  input  logic          b2_in,
  output logic          b2_out,
  output logic          b2_oe
);
  localparam int NP = 2;

  logic [DW-1:0] pin_in_v  [NP];
  logic [DW-1:0] pin_out_v [NP];
  logic [DW-1:0] dat_view  [NP];
  logic [CW-1:0] ctl_view  [NP];
  logic [NP-1:0] l1_v, l2_in_v, l2_out_v, l2_oe_v, irq_v, sel_v;
  logic [NP-1:0] dat_wr, dat_rd, ctl_wr, trig;
  logic          rd_acc, wr_acc;

  always_comb begin
    rd_acc      = cs & rd;
    wr_acc      = cs & wr;
    pin_in_v[0] = pa_in;
    pin_in_v[1] = pb_in;
    l1_v        = {b1_in, a1_in};
    l2_in_v     = {b2_in, a2_in};
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam logic [1:0] RS_DAT = 2'(2 * p);
    localparam logic [1:0] RS_CTL = 2'(2 * p + 1);

    always_comb begin
      dat_wr[p] = wr_acc & (rsel == RS_DAT);
      dat_rd[p] = rd_acc & (rsel == RS_DAT) & sel_v[p];
      ctl_wr[p] = wr_acc & (rsel == RS_CTL);
    end

    if (p == 0) begin : g_rd_strobe
      always_comb trig[p] = dat_rd[p];
    end else begin : g_wr_strobe
      always_comb trig[p] = dat_wr[p] & sel_v[p];
    end

    par_io_dir_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(dat_wr[p]), .sel_data(sel_v[p]),
      .wdata(wdata), .pin_in(pin_in_v[p]), .rd_view(dat_view[p]),
      .pins_out(pin_out_v[p])
    );

    par_io_handshake u_hs (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr[p]),
      .ctl_wdata(wdata[C_WR_BITS-1:0]), .data_rd(dat_rd[p]),
      .strobe_trig(trig[p]), .l1_in(l1_v[p]), .l2_in(l2_in_v[p]),
      .ctl_view(ctl_view[p]), .sel_data(sel_v[p]), .irq(irq_v[p]),
      .l2_out(l2_out_v[p]), .l2_oe(l2_oe_v[p])
    );
  end

  always_comb begin
    unique case (rsel)
      RS_DAT_A: rdata = dat_view[0];
      RS_CTL_A: rdata = DW'(ctl_view[0]);
      RS_DAT_B: rdata = dat_view[1];
      default:  rdata = DW'(ctl_view[1]);
    endcase
    pa_out = pin_out_v[0];
    pb_out = pin_out_v[1];
    irq_a  = irq_v[0];
    irq_b  = irq_v[1];
    a2_out = l2_out_v[0];
    a2_oe  = l2_oe_v[0];
    b2_out = l2_out_v[1];
    b2_oe  = l2_oe_v[1];
  end

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (ctl_view[0][C_FLAG1] || ctl_view[0][C_FLAG2]));
endmodule

// File: tb/par_io_adapter_test.sv
module par_io_adapter_test;
  logic clk = 1'b0;
  logic rst_n;
  logic cs, rd, wr;
  logic [1:0] rsel;
  logic [7:0] wdata, rdata, pa_in, pa_out, pb_in, pb_out;
  logic irq_a, irq_b, a1_in, a2_in, a2_out, a2_oe, b1_in, b2_in, b2_out, b2_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_or [2], m_ddr [2], m_pin [2];
  logic [5:0] m_ctl [2];
  logic m_f1 [2], m_f2 [2], m_l2 [2], m_p1 [2], m_p2 [2], m_l1n [2], m_l2n [2];

  always #5 clk = ~clk;

  par_io_adapter uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .rsel(rsel),
    .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b),
    .pa_in(pa_in), .pa_out(pa_out), .pb_in(pb_in), .pb_out(pb_out),
    .a1_in(a1_in), .a2_in(a2_in), .a2_out(a2_out), .a2_oe(a2_oe),
    .b1_in(b1_in), .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(int p, logic [1:0] rs);
    if (rs[0])
      return {m_f1[p], m_f2[p] & ~m_ctl[p][5], m_ctl[p]};
    if (m_ctl[p][2])
      return (m_or[p] & m_ddr[p]) | (m_pin[p] & ~m_ddr[p]);
    return m_ddr[p];
  endfunction

  function automatic logic edge_act(logic nw, logic pv, logic rise);
    return rise ? (nw & ~pv) : (~nw & pv);
  endfunction

  task automatic model_step(logic c, logic r, logic w, logic [1:0] rs, logic [7:0] wd);
    for (int p = 0; p < 2; p++) begin
      logic ctlw, drd, dwr, a1, a2, stb, trg, nl2;
      ctlw = c & w & (rs == 2'(2*p+1));
      dwr  = c & w & (rs == 2'(2*p));
      drd  = c & r & (rs == 2'(2*p)) & m_ctl[p][2];
      a1   = edge_act(m_l1n[p], m_p1[p], m_ctl[p][1]);
      a2   = edge_act(m_l2n[p], m_p2[p], m_ctl[p][4]) & ~m_ctl[p][5];
      stb  = m_ctl[p][5] & ~m_ctl[p][4];
      trg  = (p == 0) ? drd : (dwr & m_ctl[p][2]);
      nl2  = m_l2[p];
      if (stb && m_ctl[p][3] && !m_l2[p]) nl2 = 1'b1;
      if (stb && !m_ctl[p][3] && a1 && !m_f1[p] && !m_l2[p]) nl2 = 1'b1;
      if (stb && trg) nl2 = 1'b0;
      if (ctlw && wd[5] && wd[4]) nl2 = wd[3];
      m_l2[p] = nl2;
      m_f1[p] = a1 | (m_f1[p] & ~drd);
      m_f2[p] = a2 | (m_f2[p] & ~drd);
      if (dwr && m_ctl[p][2])  m_or[p]  = wd;
      if (dwr && !m_ctl[p][2]) m_ddr[p] = wd;
      if (ctlw) m_ctl[p] = wd[5:0];
      m_p1[p] = m_l1n[p];
      m_p2[p] = m_l2n[p];
    end
  endtask

  task automatic cycle(logic c, logic r, logic w, logic [1:0] rs, logic [7:0] wd, string tag);
    @(negedge clk);
    cs = c; rd = r; wr = w; rsel = rs; wdata = wd;
    pa_in = m_pin[0]; pb_in = m_pin[1];
    a1_in = m_l1n[0]; a2_in = m_l2n[0]; b1_in = m_l1n[1]; b2_in = m_l2n[1];
    #1;
    if (c && r) chk(tag, rdata, exp_read(rs[1], rs));
    model_step(c, r, w, rs, wd);
    @(posedge clk);
    #1;
    // R3 pins, R7 irq, R9 oe, R10/R11 line 2
    chk("R3", pa_out, m_or[0] & m_ddr[0]);
    chk("R3", pb_out, m_or[1] & m_ddr[1]);
    chk("R7", irq_a, (m_f1[0] & m_ctl[0][0]) | (m_f2[0] & m_ctl[0][3] & ~m_ctl[0][5]));
    chk("R7", irq_b, (m_f1[1] & m_ctl[1][0]) | (m_f2[1] & m_ctl[1][3] & ~m_ctl[1][5]));
    chk("R9", a2_oe, m_ctl[0][5]);
    chk("R9", b2_oe, m_ctl[1][5]);
    chk("R10", a2_out, m_l2[0]);
    chk("R11", b2_out, m_l2[1]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 2'd0, 8'h00, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < 2; p++) begin
      m_or[p] = 0; m_ddr[p] = 0; m_pin[p] = 0; m_ctl[p] = 0;
      m_f1[p] = 0; m_f2[p] = 0; m_l2[p] = 1; m_p1[p] = 0; m_p2[p] = 0;
      m_l1n[p] = 0; m_l2n[p] = 0;
    end
    rst_n = 1'b0; cs = 0; rd = 0; wr = 0; rsel = 0; wdata = 0;
    pa_in = 0; pb_in = 0; a1_in = 0; a2_in = 0; b1_in = 0; b2_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R14 reset state
    chk("R14", a2_out, 1); chk("R14", b2_out, 1);
    chk("R14", a2_oe, 0);  chk("R14", b2_oe, 0);
    chk("R14", irq_a, 0);  chk("R14", irq_b, 0);
    chk("R14", pa_out, 0); chk("R14", pb_out, 0);
    cycle(1, 1, 0, 2'd1, 0, "R14");
    cycle(1, 1, 0, 2'd2, 0, "R14");

    // R1 direction then latch, R2 merged read
    cycle(1, 0, 1, 2'd0, 8'hF0, "R1");
    cycle(1, 1, 0, 2'd0, 0, "R1");
    cycle(1, 0, 1, 2'd1, 8'h04, "R1");
    cycle(1, 0, 1, 2'd0, 8'hA5, "R3");
    m_pin[0] = 8'h3C;
    cycle(1, 1, 0, 2'd0, 0, "R2");

    // R4 flags are read only
    cycle(1, 0, 1, 2'd1, 8'hC7, "R4");
    cycle(1, 1, 0, 2'd1, 0, "R4");

    // R5 rising edge on A1, R7 irq, R8 clear by latch read
    m_l1n[0] = 1; idle(1);
    cycle(1, 1, 0, 2'd1, 0, "R5");
    cycle(1, 1, 0, 2'd0, 0, "R8");
    cycle(1, 1, 0, 2'd1, 0, "R8");
    // R5 falling edge selected on B1
    cycle(1, 0, 1, 2'd3, 8'h05, "R5");
    m_l1n[1] = 1; idle(1);
    m_l1n[1] = 0; idle(1);
    cycle(1, 1, 0, 2'd3, 0, "R5");
    // R8 edge in same cycle as the clearing read
    m_l1n[1] = 1; idle(1);
    m_l1n[1] = 0;
    cycle(1, 1, 0, 2'd2, 0, "R8");
    cycle(1, 1, 0, 2'd3, 0, "R8");

    // R6 line 2 input edge, irq enable bit 3
    cycle(1, 0, 1, 2'd1, 8'h1C, "R6");
    m_l2n[0] = 1; idle(1);
    cycle(1, 1, 0, 2'd1, 0, "R6");
    cycle(1, 1, 0, 2'd0, 0, "R6");

    // R9 set/reset output
    cycle(1, 0, 1, 2'd1, 8'h34, "R9");
    cycle(1, 0, 1, 2'd1, 8'h3C, "R9");
    // R13 line 2 output ignores pin activity
    m_l2n[0] = 0; idle(1); m_l2n[0] = 1; idle(1);
    cycle(1, 1, 0, 2'd1, 0, "R13");

    // R10 port A strobe with bus-cycle release
    cycle(1, 0, 1, 2'd1, 8'h2C, "R10");
    cycle(1, 1, 0, 2'd0, 0, "R10");
    idle(2);
    // R12 release on line 1 edge with flag 1 clear
    cycle(1, 0, 1, 2'd1, 8'h26, "R12");
    cycle(1, 1, 0, 2'd0, 0, "R12");
    idle(1);
    m_l1n[0] = 0; idle(1);
    m_l1n[0] = 1; idle(1);
    // R12 no release while flag 1 pending
    cycle(1, 1, 0, 2'd0, 0, "R12");
    m_l1n[0] = 0; idle(1);
    m_l1n[0] = 1; idle(1);
    cycle(1, 1, 0, 2'd0, 0, "R12");
    m_l1n[0] = 0; idle(1);
    m_l1n[0] = 1; idle(1);
    m_l1n[0] = 0; idle(1);
    m_l1n[0] = 1; idle(1);

    // R11 port B write strobe
    cycle(1, 0, 1, 2'd3, 8'h2C, "R11");
    cycle(1, 0, 1, 2'd2, 8'h5A, "R11");
    idle(2);
    cycle(1, 0, 1, 2'd3, 8'h24, "R11");
    cycle(1, 0, 1, 2'd2, 8'h11, "R11");
    m_l1n[1] = 1; idle(1);
    m_l1n[1] = 0; idle(2);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [1:0] rs;
      logic [7:0] wd;
      op = $urandom_range(0, 9);
      rs = 2'($urandom_range(0, 3));
      wd = 8'($urandom);
      for (int p = 0; p < 2; p++) begin
        if ($urandom_range(0, 3) == 0) m_l1n[p] = ~m_l1n[p];
        if ($urandom_range(0, 3) == 0) m_l2n[p] = ~m_l2n[p];
        if ($urandom_range(0, 7) == 0) m_pin[p] = 8'($urandom);
      end
      if (op < 3)      cycle(1, 0, 1, rs, wd, "R1");
      else if (op < 6) cycle(1, 1, 0, rs, 0, rs[0] ? "R4" : "R2");
      else if (op < 7) cycle(0, 1, 1, rs, wd, "R1");
      else             cycle(1, 0, 0, rs, wd, "R1");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule